// File: doc/BRIEF.md
# CAN Acceptance Mask Selector

This block holds the acceptance masks used by a CAN receive path and, for every lookup, chooses which of them applies. One register bank contains a global mask, two dedicated legacy masks and, when the build includes them, one individual mask per receive slot. A lookup names either a receive slot or a FIFO filter table element by index. The block returns the chosen mask and a flag that says whether the received identifier agrees with the filter on every bit the mask cares about.

Two mode inputs steer the choice. The individual-masking input makes every lookup use the mask that belongs to its own index, and the legacy masks then play no part. The FIFO-enable input moves the legacy masks from slots 14 and 15 onto filter elements 6 and 7. Software writes the masks through a simple write port. The port works only while the freeze input is high, so a mask cannot change under live traffic.

The lookup path is combinational. A register write takes effect from the clock edge that captures it.

Top module: `can_mask_sel`

## Requirements
- R1: After a synchronous reset, the global mask, both legacy masks and all individual masks read as all ones (0xFFFF_FFFF at the default 32-bit width).
- R2: With individual masking off, a slot lookup (`q_fifo_i`=0) at index 14 returns legacy mask A.
- R3: With individual masking off, a slot lookup at index 15 returns legacy mask B.
- R4: With individual masking off, a slot lookup at any index other than 14 and 15 returns the global mask.
- R5: A filter-element lookup (`q_fifo_i`=1) with individual masking off returns legacy mask A for element 6 and legacy mask B for element 7 when `fifo_en_i`=1. It returns the global mask for every other element, and for all elements when `fifo_en_i`=0.
- R6: With `indiv_mode_i`=1, a lookup of either kind at index k returns individual mask k, and neither legacy mask has any effect.
- R7: When `freeze_i`=1, a write with `wr_en_i`=1 stores `wr_data_i` into the register chosen by `wr_sel_i`: 0 selects the global mask, 1 legacy mask A, 2 legacy mask B, and 3 individual mask `wr_idx_i`. The new value is visible to lookups from the next clock cycle.
- R8: A write with `freeze_i`=0 is ignored, and every mask register keeps its value.
- R9: `q_match_o` is 1 exactly when ((`q_id_i` XOR `q_filter_i`) AND `q_mask_o`) is zero. A mask bit of 1 forces the identifier bit to match, and a mask bit of 0 ignores that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Freeze mode; mask writes are allowed only while high |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 2 | Target register: 0 global, 1 legacy A, 2 legacy B, 3 individual |
| wr_idx_i | input | IDX_W | Individual mask index for wr_sel_i = 3 |
| wr_data_i | input | ID_W | Write data |
| indiv_mode_i | input | 1 | Per-index individual masking enable |
| fifo_en_i | input | 1 | FIFO filter table mode |
| q_fifo_i | input | 1 | Lookup kind: 0 receive slot, 1 filter element |
| q_idx_i | input | IDX_W | Slot or element index |
| q_id_i | input | ID_W | Received identifier |
| q_filter_i | input | ID_W | Filter value to compare against |
| q_mask_o | output | ID_W | Selected mask |
| q_match_o | output | 1 | Masked comparison result |

## Verification
The bench favours indices 6, 7, 14 and 15 and changes both mode inputs freely, because that is where the mapping can go wrong. If the legacy masks were tied to the element numbers in slot lookups, or stayed active without FIFO mode, lookups at 6 and 7 would wrongly return a legacy mask. If they were not disabled under individual masking, lookups at 14 and 15 would show a legacy value where the per-index mask is expected. Writes are attempted with freeze low, and a design that lets them through would show the written value on the next lookup. The filter is often set to the identifier with a single bit flipped, so that an inverted mask sense or a dropped bit shows up in the match flag.

// File: rtl/can_mask_pkg.sv
package can_mask_pkg;

    localparam int unsigned MAX_ID_W = 64;

    // target register of a mask write
    typedef enum logic [1:0] {
        MSEL_GLOBAL = 2'd0,
        MSEL_LEG_A  = 2'd1,
        MSEL_LEG_B  = 2'd2,
        MSEL_INDIV  = 2'd3
    } msel_e;

    // which mask feeds a lookup
    typedef enum logic [1:0] {
        SRC_GLOBAL,
        SRC_LEG_A,
        SRC_LEG_B,
        SRC_INDIV
    } src_e;

    typedef struct packed {
        logic       is_fifo;
        logic [7:0] idx;
    } lookup_t;

    // a set mask bit demands equality, a clear one ignores the bit
    function automatic logic masked_equal(input logic [MAX_ID_W-1:0] id,
                                          input logic [MAX_ID_W-1:0] filt,
                                          input logic [MAX_ID_W-1:0] mask);
        return ((id ^ filt) & mask) == '0;
    endfunction

endpackage

// File: rtl/can_mask_regs.sv
module can_mask_regs
    import can_mask_pkg::*;
#(
    parameter int unsigned ID_W      = 32,
    parameter int unsigned N_SLOTS   = 16,
    parameter bit          HAS_INDIV = 1'b1,
    localparam int unsigned IDX_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze_i,
    input  logic             wr_en_i,
    input  msel_e            wr_sel_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [ID_W-1:0]  wr_data_i,
    output logic [ID_W-1:0]  glob_q,
    output logic [ID_W-1:0]  leg_a_q,
    output logic [ID_W-1:0]  leg_b_q,
    output logic [ID_W-1:0]  ind_q [N_SLOTS]
);

    localparam logic [ID_W-1:0] ALL_ONES = '1;

    logic wr_ok;
    assign wr_ok = wr_en_i && freeze_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q  <= ALL_ONES;
            leg_a_q <= ALL_ONES;
            leg_b_q <= ALL_ONES;
        end else if (wr_ok) begin
            case (wr_sel_i)
                MSEL_GLOBAL: glob_q  <= wr_data_i;
                MSEL_LEG_A:  leg_a_q <= wr_data_i;
                MSEL_LEG_B:  leg_b_q <= wr_data_i;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_INDIV) begin : g_indiv
            for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
                always_ff @(posedge clk) begin
                    if (rst) begin
                        ind_q[s] <= ALL_ONES;
                    end else if (wr_ok && wr_sel_i == MSEL_INDIV
                                 && wr_idx_i == IDX_W'(s)) begin
                        ind_q[s] <= wr_data_i;
                    end
                end
            end
        end else begin : g_no_indiv
            for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
                assign ind_q[s] = ALL_ONES;
            end
        end
    endgenerate

endmodule

// File: rtl/can_mask_pick.sv
module can_mask_pick
    import can_mask_pkg::*;
#(
    parameter int unsigned ID_W        = 32,
    parameter int unsigned N_SLOTS     = 16,
    parameter bit          HAS_INDIV   = 1'b1,
    parameter int unsigned LEG_SLOT_A  = 14,
    parameter int unsigned LEG_SLOT_B  = 15,
    parameter int unsigned FIFO_ELEM_A = 6,
    parameter int unsigned FIFO_ELEM_B = 7,
    localparam int unsigned IDX_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             indiv_mode_i,
    input  logic             fifo_en_i,
    input  logic             q_fifo_i,
    input  logic [IDX_W-1:0] q_idx_i,
    input  logic [ID_W-1:0]  glob_q,
    input  logic [ID_W-1:0]  leg_a_q,
    input  logic [ID_W-1:0]  leg_b_q,
    input  logic [ID_W-1:0]  ind_q [N_SLOTS],
    output src_e             src_o,
    output logic [ID_W-1:0]  mask_o
);

    logic in_range;
    logic slot_a, slot_b, elem_a, elem_b;

    assign in_range = 32'(q_idx_i) < N_SLOTS;
    assign slot_a   = !q_fifo_i && 32'(q_idx_i) == LEG_SLOT_A;
    assign slot_b   = !q_fifo_i && 32'(q_idx_i) == LEG_SLOT_B;
    assign elem_a   = q_fifo_i && fifo_en_i && 32'(q_idx_i) == FIFO_ELEM_A;
    assign elem_b   = q_fifo_i && fifo_en_i && 32'(q_idx_i) == FIFO_ELEM_B;

    always_comb begin
        if (HAS_INDIV && indiv_mode_i && in_range) begin
            src_o = SRC_INDIV;
        end else if (slot_a || elem_a) begin
            src_o = SRC_LEG_A;
        end else if (slot_b || elem_b) begin
            src_o = SRC_LEG_B;
        end else begin
            src_o = SRC_GLOBAL;
        end
    end

    always_comb begin
        case (src_o)
            SRC_INDIV: mask_o = ind_q[in_range ? q_idx_i : '0];
            SRC_LEG_A: mask_o = leg_a_q;
            SRC_LEG_B: mask_o = leg_b_q;
            default:   mask_o = glob_q;
        endcase
    end

endmodule

// File: rtl/can_mask_cmp.sv
module can_mask_cmp
    import can_mask_pkg::*;
#(
    parameter int unsigned ID_W = 32
) (
    input  logic [ID_W-1:0] id_i,
    input  logic [ID_W-1:0] filt_i,
    input  logic [ID_W-1:0] mask_i,
    output logic            match_o
);

    assign match_o = masked_equal(MAX_ID_W'(id_i), MAX_ID_W'(filt_i),
                                  MAX_ID_W'(mask_i));

endmodule

// File: rtl/can_mask_sel.sv
module can_mask_sel
    import can_mask_pkg::*;
#(
    parameter int unsigned ID_W        = 32,
    parameter int unsigned N_SLOTS     = 16,
    parameter bit          HAS_INDIV   = 1'b1,
    parameter int unsigned LEG_SLOT_A  = 14,
    parameter int unsigned LEG_SLOT_B  = 15,
    parameter int unsigned FIFO_ELEM_A = 6,
    parameter int unsigned FIFO_ELEM_B = 7,
    localparam int unsigned IDX_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [ID_W-1:0]  wr_data_i,
    input  logic             indiv_mode_i,
    input  logic             fifo_en_i,
    input  logic             q_fifo_i,
    input  logic [IDX_W-1:0] q_idx_i,
    input  logic [ID_W-1:0]  q_id_i,
    input  logic [ID_W-1:0]  q_filter_i,
    output logic [ID_W-1:0]  q_mask_o,
    output logic             q_match_o
);

    logic [ID_W-1:0] glob_q, leg_a_q, leg_b_q;
    logic [ID_W-1:0] ind_q [N_SLOTS];
    src_e            src;

    can_mask_regs #(
        .ID_W(ID_W), .N_SLOTS(N_SLOTS), .HAS_INDIV(HAS_INDIV)
    ) u_regs (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .wr_en_i(wr_en_i),
        .wr_sel_i(msel_e'(wr_sel_i)), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .glob_q(glob_q), .leg_a_q(leg_a_q),
        .leg_b_q(leg_b_q), .ind_q(ind_q)
    );

    can_mask_pick #(
        .ID_W(ID_W), .N_SLOTS(N_SLOTS), .HAS_INDIV(HAS_INDIV),
        .LEG_SLOT_A(LEG_SLOT_A), .LEG_SLOT_B(LEG_SLOT_B),
        .FIFO_ELEM_A(FIFO_ELEM_A), .FIFO_ELEM_B(FIFO_ELEM_B)
    ) u_pick (
        .indiv_mode_i(indiv_mode_i), .fifo_en_i(fifo_en_i),
        .q_fifo_i(q_fifo_i), .q_idx_i(q_idx_i), .glob_q(glob_q),
        .leg_a_q(leg_a_q), .leg_b_q(leg_b_q), .ind_q(ind_q),
        .src_o(src), .mask_o(q_mask_o)
    );

    can_mask_cmp #(.ID_W(ID_W)) u_cmp (
        .id_i(q_id_i), .filt_i(q_filter_i), .mask_i(q_mask_o),
        .match_o(q_match_o)
    );

endmodule

// File: rtl/can_mask_sel_chk.sv
module can_mask_sel_chk #(
    parameter int unsigned ID_W        = 32,
    parameter int unsigned N_SLOTS     = 16,
    parameter bit          HAS_INDIV   = 1'b1,
    parameter int unsigned LEG_SLOT_A  = 14,
    parameter int unsigned FIFO_ELEM_B = 7,
    localparam int unsigned IDX_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             freeze_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [ID_W-1:0]  wr_data_i,
    input logic             indiv_mode_i,
    input logic             fifo_en_i,
    input logic             q_fifo_i,
    input logic [IDX_W-1:0] q_idx_i,
    input logic [ID_W-1:0]  q_id_i,
    input logic [ID_W-1:0]  q_filter_i,
    input logic [ID_W-1:0]  q_mask_o,
    input logic             q_match_o,
    input logic [ID_W-1:0]  glob_q,
    input logic [ID_W-1:0]  leg_a_q,
    input logic [ID_W-1:0]  leg_b_q,
    input logic [ID_W-1:0]  ind_q [N_SLOTS]
);

    logic indiv_on;
    assign indiv_on = HAS_INDIV && indiv_mode_i && (32'(q_idx_i) < N_SLOTS);

    a_r1_reset_ones: assert property (@(posedge clk)
        rst |=> (&glob_q) && (&leg_a_q) && (&leg_b_q));

    a_r2_slot_leg_a: assert property (@(posedge clk) disable iff (rst)
        (!indiv_on && !q_fifo_i && 32'(q_idx_i) == LEG_SLOT_A)
        |-> q_mask_o == leg_a_q);

    a_r5_elem_leg_b: assert property (@(posedge clk) disable iff (rst)
        (!indiv_on && q_fifo_i && fifo_en_i && 32'(q_idx_i) == FIFO_ELEM_B)
        |-> q_mask_o == leg_b_q);

    a_r6_indiv_mask: assert property (@(posedge clk) disable iff (rst)
        indiv_on |-> q_mask_o == ind_q[q_idx_i]);

    a_r7_write_leg_a: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && wr_en_i && wr_sel_i == 2'd1)
        |=> leg_a_q == $past(wr_data_i));

    a_r8_no_write_thawed: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> $stable(glob_q) && $stable(leg_a_q) && $stable(leg_b_q));

    a_r9_match_flag: assert property (@(posedge clk) disable iff (rst)
        q_match_o == (((q_id_i ^ q_filter_i) & q_mask_o) == '0));

endmodule

bind can_mask_sel can_mask_sel_chk #(
    .ID_W(ID_W), .N_SLOTS(N_SLOTS), .HAS_INDIV(HAS_INDIV),
    .LEG_SLOT_A(LEG_SLOT_A), .FIFO_ELEM_B(FIFO_ELEM_B)
) u_chk (
    .clk(clk), .rst(rst), .freeze_i(freeze_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .indiv_mode_i(indiv_mode_i), .fifo_en_i(fifo_en_i),
    .q_fifo_i(q_fifo_i), .q_idx_i(q_idx_i), .q_id_i(q_id_i),
    .q_filter_i(q_filter_i), .q_mask_o(q_mask_o), .q_match_o(q_match_o),
    .glob_q(glob_q), .leg_a_q(leg_a_q), .leg_b_q(leg_b_q), .ind_q(ind_q)
);

// File: tb/can_mask_sel_tb.sv
`timescale 1ns/1ps
module can_mask_sel_tb;

    localparam int ID_W = 32;
    localparam int NS   = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            freeze_i, wr_en_i, indiv_mode_i, fifo_en_i, q_fifo_i;
    logic [1:0]      wr_sel_i;
    logic [3:0]      wr_idx_i, q_idx_i;
    logic [ID_W-1:0] wr_data_i, q_id_i, q_filter_i, q_mask_o;
    logic            q_match_o;

    always #2.5 clk = ~clk;

    can_mask_sel u_dut (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .indiv_mode_i(indiv_mode_i), .fifo_en_i(fifo_en_i),
        .q_fifo_i(q_fifo_i), .q_idx_i(q_idx_i), .q_id_i(q_id_i),
        .q_filter_i(q_filter_i), .q_mask_o(q_mask_o), .q_match_o(q_match_o)
    );

    // behavioural reference state
    logic [ID_W-1:0] m_glob, m_la, m_lb;
    logic [ID_W-1:0] m_ind [NS];
    int checks = 0, errors = 0;
    string ovr = "";
    bit done = 0;

    function automatic logic [ID_W-1:0] ref_mask();
        if (indiv_mode_i) return m_ind[q_idx_i];
        if (!q_fifo_i && q_idx_i == 14) return m_la;
        if (!q_fifo_i && q_idx_i == 15) return m_lb;
        if (q_fifo_i && fifo_en_i && q_idx_i == 6) return m_la;
        if (q_fifo_i && fifo_en_i && q_idx_i == 7) return m_lb;
        return m_glob;
    endfunction

    function automatic string ref_tag();
        if (ovr != "") return ovr;
        if (indiv_mode_i) return "R6";
        if (q_fifo_i) return "R5";
        if (q_idx_i == 14) return "R2";
        if (q_idx_i == 15) return "R3";
        return "R4";
    endfunction

    task automatic model_reset();
        m_glob = '1; m_la = '1; m_lb = '1;
        for (int i = 0; i < NS; i++) m_ind[i] = '1;
    endtask

    // compare with the inputs already applied, then account for the write
    // that the coming rising edge captures, then move to the falling edge
    task automatic tick();
        logic [ID_W-1:0] em;
        logic            ematch;
        #1;
        em     = ref_mask();
        ematch = ((q_id_i ^ q_filter_i) & em) == '0;
        checks++;
        if (q_mask_o !== em) begin
            errors++;
            $display("FAIL %s mask actual %h expected %h", ref_tag(), q_mask_o, em);
        end
        checks++;
        if (q_match_o !== ematch) begin
            errors++;
            $display("FAIL R9 match actual %b expected %b", q_match_o, ematch);
        end
        if (rst) model_reset();
        else if (wr_en_i && freeze_i) begin
            case (wr_sel_i)
                2'd0: m_glob = wr_data_i;
                2'd1: m_la   = wr_data_i;
                2'd2: m_lb   = wr_data_i;
                default: m_ind[wr_idx_i] = wr_data_i;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic set_q(input logic f, input logic [3:0] idx,
                         input logic [ID_W-1:0] id, input logic [ID_W-1:0] flt);
        q_fifo_i = f; q_idx_i = idx; q_id_i = id; q_filter_i = flt;
    endtask

    task automatic wr(input logic frz, input logic [1:0] sel,
                      input logic [3:0] idx, input logic [ID_W-1:0] d);
        freeze_i = frz; wr_en_i = 1'b1; wr_sel_i = sel; wr_idx_i = idx;
        wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; freeze_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_idx_i = 0;
        wr_data_i = 0; indiv_mode_i = 0; fifo_en_i = 0;
        set_q(0, 0, 0, 0);
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;

        // R1: every register reads all ones right after reset
        ovr = "R1";
        set_q(0, 3, 32'h0, 32'hFFFF_FFFF); tick();
        set_q(0, 14, 32'h0, 32'h1); tick();
        set_q(0, 15, 32'h0, 32'h1); tick();
        indiv_mode_i = 1; set_q(1, 9, 32'h5, 32'h5); tick();
        indiv_mode_i = 0;

        // R7: freeze-mode writes land in the chosen register
        ovr = "R7";
        wr(1, 2'd0, 0, 32'h0000_00FF);
        wr(1, 2'd1, 0, 32'h0000_FF00);
        wr(1, 2'd2, 0, 32'h00FF_0000);
        wr(1, 2'd3, 14, 32'hFF00_0000);
        set_q(0, 14, 32'h1234_5678, 32'h1234_0078); tick();
        set_q(0, 2, 32'h1234_5678, 32'h1234_5600); tick();

        // R8: a thawed write changes nothing
        ovr = "R8";
        wr(0, 2'd1, 0, 32'hDEAD_BEEF);
        wr(0, 2'd0, 0, 32'h0);
        wr(0, 2'd3, 14, 32'h0);
        set_q(0, 14, 32'h0, 32'h0000_0100); tick();
        set_q(0, 5, 32'h0, 32'h0000_0001); tick();
        indiv_mode_i = 1; set_q(0, 14, 32'h0, 32'h0100_0000); tick();
        indiv_mode_i = 0;

        // R5: FIFO element mapping with and without fifo_en
        ovr = "";
        fifo_en_i = 1;
        set_q(1, 6, 32'h0, 32'h0); tick();
        set_q(1, 7, 32'h0, 32'h0); tick();
        set_q(1, 14, 32'h0, 32'h0); tick();
        fifo_en_i = 0;
        set_q(1, 6, 32'h0, 32'h0000_0100); tick();

        // randomised mix, biased onto the mapped indices
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] pick;
            int         r;
            r = $urandom_range(0, 9);
            case (r)
                0: pick = 6;
                1: pick = 7;
                2: pick = 14;
                3: pick = 15;
                default: pick = 4'($urandom_range(0, 15));
            endcase
            freeze_i     = $urandom_range(0, 1) == 1;
            wr_en_i      = $urandom_range(0, 2) == 0;
            wr_sel_i     = 2'($urandom_range(0, 3));
            wr_idx_i     = 4'($urandom_range(0, 15));
            wr_data_i    = $urandom() & $urandom();
            indiv_mode_i = $urandom_range(0, 3) == 0;
            fifo_en_i    = $urandom_range(0, 1) == 1;
            q_fifo_i     = $urandom_range(0, 1) == 1;
            q_idx_i      = pick;
            q_id_i       = $urandom();
            r = $urandom_range(0, 3);
            q_filter_i   = (r == 0) ? q_id_i
                         : (r == 1) ? q_id_i ^ (32'h1 << $urandom_range(0, 31))
                         : $urandom();
            tick();
        end
        wr_en_i = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule